// File: doc/BRIEF.md
# Prescaled Up-Counter Timer with Match Flags

This block is a 16-bit interval timer that software drives through a small synchronous register port. A free-running prescale counter divides the clock. Each time the prescale counter reaches its terminal count, the main timer counter advances by one. Four compare registers watch the timer counter. When the counter steps onto a compare value, that channel raises a sticky flag, and any raised flag drives the single interrupt line.

Software programs the divide ratio and the four compare values. It starts or freezes counting with a run bit and can hold both counters at zero with a clear bit. It acknowledges events by writing ones into the flag register. A wrap of the timer counter from its top value to zero raises nothing by itself. To detect overflow, software points a compare register at zero or at the top value.

Top module: `pscl_timer`

## Requirements
- R1: After a synchronous reset every register reads zero (flags, control, timer counter, prescale value, prescale counter, all four compare values) and `irq` is low.
- R2: The flag register (word offset 0x00) holds channel k's flag in bit k for k = 0..3, and bits 31:4 read as zero. Writing a 1 to bit k clears flag k, and writing a 0 leaves it unchanged.
- R3: While running, the prescale counter counts 0, 1, … up to the prescale value and then returns to 0. On that terminal cycle the timer counter advances by one. A prescale value of 0 therefore advances the timer on every running cycle. After S running cycles from zero with prescale value P, the timer reads S/(P+1) and the prescale counter reads S mod (P+1).
- R4: Control bit 0 is the run bit. While it is 0, both counters keep their values.
- R5: Control bit 1 is the hold-clear bit. While it is 1, both counters are forced to zero at every rising edge, regardless of the run bit. A bus write to either counter in that cycle is lost.
- R6: The timer counter is 16 bits wide and steps from 0xFFFF to 0x0000. That wrap sets no flag unless a compare register holds 0x0000.
- R7: Flag k is set at the edge where the timer counter advances by counting onto compare value k. Loading that value by a bus write does not set the flag.
- R8: If a write-one clear of flag k lands on the same edge as a new match on channel k, the flag ends up set.
- R9: `irq` is high exactly when at least one flag is set.
- R10: The register map uses word offsets 0x00 flags, 0x04 control, 0x08 timer counter, 0x0C prescale value, 0x10 prescale counter, and 0x18/0x1C/0x20/0x24 for compare values 0..3. Control reads back only bits 1:0. Unmapped or misaligned addresses read zero and ignore writes. Read data appears on `bus_rdata` in the cycle after `bus_rd` is sampled and is zero when no read was requested.
- R11: Writing 0x08 or 0x10 loads the timer counter or the prescale counter. That load takes priority over counting but not over hold-clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, all state updates on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe for the register port |
| bus_rd | input | 1 | Read strobe for the register port |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq | output | 1 | OR of the four match flags |

## Verification
The hardest situation to reach is a flag clear that coincides with a compare hit. The write and the counter step must meet on one exact edge. The stimulus arms the run bit with the prescale value at zero and then issues the clear as the very next bus write, so that the write edge is also the step edge onto the compare value. The 0xFFFF wrap needs no long wait: the counter is loaded near its top value through the bus. Prescale ratios 0..3 are swept against several run lengths, and the bench compares the results with quotient and remainder arithmetic.

// File: rtl/ptmr_pkg.sv
package ptmr_pkg;

    // word indices (byte offset / 4) of the register map
    localparam int WORD_FLAG = 0;
    localparam int WORD_CTRL = 1;
    localparam int WORD_TC   = 2;
    localparam int WORD_PR   = 3;
    localparam int WORD_PC   = 4;
    localparam int WORD_MR0  = 6;

    // control word: bit 1 hold-clear, bit 0 run
    typedef struct packed {
        logic hold_clr;
        logic run;
    } ctrl_t;

    typedef enum logic [2:0] {
        RS_NONE,
        RS_FLAG,
        RS_CTRL,
        RS_TC,
        RS_PR,
        RS_PC,
        RS_MR
    } rsel_e;

    function automatic rsel_e word_sel(input int w, input int n_match);
        if (w == WORD_FLAG)                              return RS_FLAG;
        else if (w == WORD_CTRL)                         return RS_CTRL;
        else if (w == WORD_TC)                           return RS_TC;
        else if (w == WORD_PR)                           return RS_PR;
        else if (w == WORD_PC)                           return RS_PC;
        else if (w >= WORD_MR0 && w < WORD_MR0 + n_match) return RS_MR;
        else                                             return RS_NONE;
    endfunction

endpackage

// File: rtl/ptmr_bus.sv
module ptmr_bus
    import ptmr_pkg::*;
#(
    parameter int CNT_W   = 16,
    parameter int N_MATCH = 4,
    parameter int AW      = 8,
    parameter int DW      = 32
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            wr_en,
    input  logic                            rd_en,
    input  logic [AW-1:0]                   addr,
    input  logic [DW-1:0]                   wdata,
    input  logic [CNT_W-1:0]                tc,
    input  logic [CNT_W-1:0]                pc,
    input  logic [N_MATCH-1:0]              flags,
    output ctrl_t                           ctrl,
    output logic [CNT_W-1:0]                pr,
    output logic [N_MATCH-1:0][CNT_W-1:0]   mr,
    output logic                            tc_ld,
    output logic                            pc_ld,
    output logic [CNT_W-1:0]                ld_val,
    output logic [N_MATCH-1:0]              flag_clr,
    output logic [DW-1:0]                   rdata
);

    localparam int WW = AW - 2;

    logic [WW-1:0] word;
    logic [WW-1:0] mr_word;
    logic          aligned;
    rsel_e         sel;
    logic [DW-1:0] rd_val;

    assign word    = addr[AW-1:2];
    assign aligned = (addr[1:0] == 2'b00);
    assign mr_word = word - WW'(WORD_MR0);
    assign sel     = aligned ? word_sel(int'(word), N_MATCH) : RS_NONE;

    // configuration registers
    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl <= '0;
            pr   <= '0;
        end else if (wr_en) begin
            case (sel)
                RS_CTRL: ctrl <= ctrl_t'(wdata[1:0]);
                RS_PR:   pr   <= wdata[CNT_W-1:0];
                default: ;
            endcase
        end
    end

    generate
        for (genvar g = 0; g < N_MATCH; g++) begin : g_mr
            always_ff @(posedge clk) begin
                if (rst)
                    mr[g] <= '0;
                else if (wr_en && sel == RS_MR && mr_word == WW'(g))
                    mr[g] <= wdata[CNT_W-1:0];
            end
        end
    endgenerate

    // strobes toward the counters and flags
    assign tc_ld    = wr_en && (sel == RS_TC);
    assign pc_ld    = wr_en && (sel == RS_PC);
    assign ld_val   = wdata[CNT_W-1:0];
    assign flag_clr = (wr_en && sel == RS_FLAG) ? wdata[N_MATCH-1:0] : '0;

    // read multiplexer
    always_comb begin
        rd_val = '0;
        case (sel)
            RS_FLAG: rd_val = DW'(flags);
            RS_CTRL: rd_val = {{(DW-2){1'b0}}, ctrl};
            RS_TC:   rd_val = DW'(tc);
            RS_PR:   rd_val = DW'(pr);
            RS_PC:   rd_val = DW'(pc);
            RS_MR: begin
                for (int i = 0; i < N_MATCH; i++)
                    if (mr_word == WW'(i))
                        rd_val = DW'(mr[i]);
            end
            default: rd_val = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            rdata <= '0;
        else
            rdata <= rd_en ? rd_val : '0;
    end

endmodule

// File: rtl/ptmr_count.sv
module ptmr_count
    import ptmr_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  ctrl_t            ctrl,
    input  logic [CNT_W-1:0] pr,
    input  logic             tc_ld,
    input  logic             pc_ld,
    input  logic [CNT_W-1:0] ld_val,
    output logic [CNT_W-1:0] tc,
    output logic [CNT_W-1:0] pc,
    output logic             step,
    output logic [CNT_W-1:0] tc_nxt
);

    logic term;

    // a prescale value lowered below the running count ends the period at once
    assign term   = (pc >= pr);
    assign step   = ctrl.run && !ctrl.hold_clr && !tc_ld && term;
    assign tc_nxt = tc + 1'b1;

    always_ff @(posedge clk) begin
        if (rst || ctrl.hold_clr) begin
            tc <= '0;
            pc <= '0;
        end else begin
            if (tc_ld)
                tc <= ld_val;
            else if (step)
                tc <= tc_nxt;

            if (pc_ld)
                pc <= ld_val;
            else if (ctrl.run)
                pc <= term ? '0 : pc + 1'b1;
        end
    end

endmodule

// File: rtl/ptmr_flags.sv
module ptmr_flags #(
    parameter int CNT_W   = 16,
    parameter int N_MATCH = 4
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          step,
    input  logic [CNT_W-1:0]              tc_nxt,
    input  logic [N_MATCH-1:0][CNT_W-1:0] mr,
    input  logic [N_MATCH-1:0]            clr,
    output logic [N_MATCH-1:0]            flags
);

    generate
        for (genvar g = 0; g < N_MATCH; g++) begin : g_ch
            logic hit;
            assign hit = step && (tc_nxt == mr[g]);

            always_ff @(posedge clk) begin
                if (rst)
                    flags[g] <= 1'b0;
                else if (hit)
                    flags[g] <= 1'b1;
                else if (clr[g])
                    flags[g] <= 1'b0;
            end
        end
    endgenerate

endmodule

// File: rtl/pscl_timer.sv
module pscl_timer
    import ptmr_pkg::*;
#(
    parameter int CNT_W   = 16,
    parameter int N_MATCH = 4,
    parameter int AW      = 8,
    parameter int DW      = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          bus_wr,
    input  logic          bus_rd,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    output logic          irq
);

    ctrl_t                         ctrl;
    logic [CNT_W-1:0]              pr;
    logic [N_MATCH-1:0][CNT_W-1:0] mr;
    logic                          tc_ld;
    logic                          pc_ld;
    logic [CNT_W-1:0]              ld_val;
    logic [N_MATCH-1:0]            flag_clr;
    logic [CNT_W-1:0]              tc;
    logic [CNT_W-1:0]              pc;
    logic                          step;
    logic [CNT_W-1:0]              tc_nxt;
    logic [N_MATCH-1:0]            flags;

    ptmr_bus #(
        .CNT_W(CNT_W), .N_MATCH(N_MATCH), .AW(AW), .DW(DW)
    ) u_bus (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (bus_wr),
        .rd_en    (bus_rd),
        .addr     (bus_addr),
        .wdata    (bus_wdata),
        .tc       (tc),
        .pc       (pc),
        .flags    (flags),
        .ctrl     (ctrl),
        .pr       (pr),
        .mr       (mr),
        .tc_ld    (tc_ld),
        .pc_ld    (pc_ld),
        .ld_val   (ld_val),
        .flag_clr (flag_clr),
        .rdata    (bus_rdata)
    );

    ptmr_count #(
        .CNT_W(CNT_W)
    ) u_count (
        .clk    (clk),
        .rst    (rst),
        .ctrl   (ctrl),
        .pr     (pr),
        .tc_ld  (tc_ld),
        .pc_ld  (pc_ld),
        .ld_val (ld_val),
        .tc     (tc),
        .pc     (pc),
        .step   (step),
        .tc_nxt (tc_nxt)
    );

    ptmr_flags #(
        .CNT_W(CNT_W), .N_MATCH(N_MATCH)
    ) u_flags (
        .clk    (clk),
        .rst    (rst),
        .step   (step),
        .tc_nxt (tc_nxt),
        .mr     (mr),
        .clr    (flag_clr),
        .flags  (flags)
    );

    assign irq = |flags;

endmodule

// File: rtl/ptmr_chk.sv
module ptmr_chk #(
    parameter int CNT_W   = 16,
    parameter int N_MATCH = 4,
    parameter int AW      = 8
) (
    input logic               clk,
    input logic               rst,
    input logic               bus_wr,
    input logic [AW-1:0]      bus_addr,
    input logic [N_MATCH-1:0] clr_bits,
    input logic [1:0]         ctrl_bits,
    input logic [CNT_W-1:0]   tc,
    input logic [CNT_W-1:0]   pc,
    input logic [N_MATCH-1:0] flags
);

    logic flag_wr;
    assign flag_wr = bus_wr && (bus_addr == '0);

    AST_HOLD_CLEAR_ZEROES: assert property (@(posedge clk) disable iff (rst)
        ctrl_bits[1] |=> (tc == '0 && pc == '0));  // R5

    AST_STOPPED_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (ctrl_bits == 2'b00 && !bus_wr) |=> ($stable(tc) && $stable(pc)));  // R4

    AST_TC_ADVANCES_ON_TERM: assert property (@(posedge clk) disable iff (rst)
        (ctrl_bits == 2'b01 && !bus_wr) |=>
            ($stable(tc) || (pc == '0 && tc == $past(tc) + 1'b1)));  // R3

    generate
        for (genvar g = 0; g < N_MATCH; g++) begin : g_fl
            AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
                (flags[g] && !(flag_wr && clr_bits[g])) |=> flags[g]);  // R2

            AST_FLAG_RISES_ON_STEP: assert property (@(posedge clk) disable iff (rst)
                $rose(flags[g]) |-> (tc != $past(tc)));  // R7
        end
    endgenerate

endmodule

bind pscl_timer ptmr_chk #(
    .CNT_W(CNT_W), .N_MATCH(N_MATCH), .AW(AW)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .clr_bits  (bus_wdata[N_MATCH-1:0]),
    .ctrl_bits (ctrl),
    .tc        (tc),
    .pc        (pc),
    .flags     (flags)
);

// File: tb/sim_pscl_timer.sv
`timescale 1ns/1ps
module sim_pscl_timer;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    int n_cmp = 0;
    int n_bad = 0;

    localparam logic [7:0] A_FLAG = 8'h00, A_CTRL = 8'h04, A_TC = 8'h08,
                           A_PR = 8'h0C, A_PC = 8'h10, A_MR0 = 8'h18;

    always #2 clk = ~clk;

    pscl_timer u0 (
        .clk       (clk),
        .rst       (rst),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    // each task starts and ends just after a falling edge, consuming one rising edge
    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_rd = 1'b1; bus_addr = a;
        @(posedge clk);
        #1;
        d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic chk_rd(input string req, input logic [7:0] a, input logic [31:0] exp);
        logic [31:0] v;
        rd(a, v);
        check(req, v, exp);
    endtask

    task automatic summary;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        #(4 * 150000);
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        summary();
        $finish;
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state of every register and irq
        check("R1 irq", {31'd0, irq}, 32'd0);
        chk_rd("R1 flags", A_FLAG, 0);
        chk_rd("R1 ctrl", A_CTRL, 0);
        chk_rd("R1 tc", A_TC, 0);
        chk_rd("R1 pr", A_PR, 0);
        chk_rd("R1 pc", A_PC, 0);
        for (int i = 0; i < 4; i++) chk_rd("R1 mr", A_MR0 + 8'(4 * i), 0);

        // R10: read data zero when no read is requested, unmapped and misaligned
        @(posedge clk); #1;
        check("R10 idle rdata", bus_rdata, 0);
        @(negedge clk);
        wr(8'h14, 32'hDEAD_BEEF);
        chk_rd("R10 unmapped 0x14", 8'h14, 0);
        chk_rd("R10 unmapped 0x28", 8'h28, 0);
        chk_rd("R10 unmapped 0xFC", 8'hFC, 0);
        wr(8'h0D, 32'h0000_0007);
        chk_rd("R10 misaligned write ignored", A_PR, 0);
        wr(A_CTRL, 32'hFFFF_FFFC);
        chk_rd("R10 ctrl upper bits", A_CTRL, 0);
        wr(A_CTRL, 32'hFFFF_FFFF);
        chk_rd("R10 ctrl reads 1:0", A_CTRL, 3);

        // R5, R11: load lost while hold-clear is set
        wr(A_TC, 32'h77);
        chk_rd("R5 tc load lost under hold", A_TC, 0);
        wr(A_CTRL, 0);
        // R11: loads
        wr(A_TC, 32'h1234);
        chk_rd("R11 tc load", A_TC, 32'h1234);
        wr(A_PC, 32'h3);
        chk_rd("R11 pc load", A_PC, 3);
        wr(A_CTRL, 2); wr(A_CTRL, 0);
        chk_rd("R5 hold-clear zeroes tc", A_TC, 0);

        // R3, R4: sweep prescale value and run length
        for (int p = 0; p < 4; p++) begin
            for (int k = 0; k < 6; k++) begin
                int n;
                int s;
                n = (k == 0) ? 0 : (k == 1) ? 1 : (k == 2) ? 2 : (k == 3) ? 5 : (k == 4) ? 9 : 14;
                wr(A_PR, 32'(p));
                wr(A_CTRL, 2); wr(A_CTRL, 0);
                wr(A_CTRL, 1);
                repeat (n) @(negedge clk);
                wr(A_CTRL, 0);
                s = n + 1;
                chk_rd("R3 tc after run", A_TC, 32'(s / (p + 1)));
                chk_rd("R3 pc after run", A_PC, 32'(s % (p + 1)));
                repeat (5) @(negedge clk);
                chk_rd("R4 tc held while stopped", A_TC, 32'(s / (p + 1)));
                chk_rd("R4 pc held while stopped", A_PC, 32'(s % (p + 1)));
            end
        end

        // R5: hold-clear overrides run and holds zero
        wr(A_PR, 0);
        wr(A_CTRL, 1);
        repeat (4) @(negedge clk);
        wr(A_CTRL, 3);
        repeat (3) @(negedge clk);
        chk_rd("R5 tc held at zero", A_TC, 0);
        chk_rd("R5 pc held at zero", A_PC, 0);
        wr(A_CTRL, 1);
        repeat (2) @(negedge clk);
        wr(A_CTRL, 0);
        chk_rd("R5 count resumes from zero", A_TC, 3);
        wr(A_CTRL, 2); wr(A_CTRL, 0);

        // R7, R9: match flag on counting, not on load
        wr(A_MR0, 5);
        wr(A_CTRL, 1);
        repeat (3) @(negedge clk);
        wr(A_CTRL, 0);
        chk_rd("R7 tc before match", A_TC, 4);
        chk_rd("R7 no flag before match", A_FLAG, 0);
        check("R9 irq low", {31'd0, irq}, 0);
        wr(A_TC, 5);
        chk_rd("R7 load onto match sets no flag", A_FLAG, 0);
        wr(A_TC, 4);
        wr(A_CTRL, 1); wr(A_CTRL, 0);
        chk_rd("R7 tc at match", A_TC, 5);
        chk_rd("R7 flag0 set", A_FLAG, 1);
        check("R9 irq high", {31'd0, irq}, 1);

        // R2: write zero no effect, write one clears
        wr(A_FLAG, 32'hFFFF_FFF0);
        chk_rd("R2 write zero keeps flag", A_FLAG, 1);
        wr(A_FLAG, 1);
        chk_rd("R2 write one clears", A_FLAG, 0);
        check("R9 irq low after clear", {31'd0, irq}, 0);

        // R8: clear and match on the same edge, set wins
        wr(A_MR0 + 8'd4, 6);
        wr(A_CTRL, 1);
        wr(A_FLAG, 2);
        wr(A_CTRL, 0);
        chk_rd("R8 set beats clear", A_FLAG, 2);
        chk_rd("R8 tc after collision", A_TC, 7);
        wr(A_FLAG, 32'hF);

        // R6: wrap behaviour
        wr(A_MR0 + 8'd8, 32'h1234);
        wr(A_MR0 + 8'd12, 32'hFFFF);
        wr(A_TC, 32'hFFFE);
        wr(A_CTRL, 1); wr(A_CTRL, 0);
        chk_rd("R6 tc at top", A_TC, 32'hFFFF);
        chk_rd("R6 flag3 at top", A_FLAG, 8);
        wr(A_FLAG, 32'hF);
        wr(A_CTRL, 1); wr(A_CTRL, 0);
        chk_rd("R6 tc wraps to zero", A_TC, 0);
        chk_rd("R6 wrap sets no flag", A_FLAG, 0);
        check("R6 irq low after wrap", {31'd0, irq}, 0);
        wr(A_MR0 + 8'd8, 0);
        wr(A_TC, 32'hFFFF);
        wr(A_CTRL, 1); wr(A_CTRL, 0);
        chk_rd("R6 overflow via compare zero", A_FLAG, 4);
        check("R9 irq from flag2", {31'd0, irq}, 1);

        // R10: compare registers read back at their offsets
        chk_rd("R10 mr0", A_MR0, 5);
        chk_rd("R10 mr1", A_MR0 + 8'd4, 6);
        chk_rd("R10 mr2", A_MR0 + 8'd8, 0);
        chk_rd("R10 mr3", A_MR0 + 8'd12, 32'hFFFF);
        rd(A_PR, v);
        check("R10 pr", v, 0);

        summary();
        $finish;
    end

endmodule